// File: doc/BRIEF.md
# Shader Flow-Control Sequencer

This block is the program counter and flow-control unit of a small vector shader core. Each cycle it presents the program counter to an instruction memory, reads back a 32-bit word and classifies it. Four opcodes steer the program: a conditional branch on the two compare flags, a conditional branch on one bit of a 16-bit boolean uniform word, a subroutine call and a program end. Every other opcode is passed to the arithmetic pipeline as a one-cycle issue pulse that carries the word. The no-operation opcode only advances the program counter.

A conditional names the address where its then-region ends and the length of an optional else-region that starts there. A call names the start and length of its subroutine region. Both are resolved with a small last-in first-out stack of (end address, resume address) pairs. In any cycle where the program counter equals the end address on top of the stack, the entry is removed and the program counter moves to the resume address. That cycle executes no instruction. The compare flags and the uniform word are plain inputs that the surrounding core drives.

Top module: `flowseq_top`

## Requirements
- R1: After reset, and until `start` is seen, `busy`, `issue_valid`, `done`, `target_err` and `stack_fault` are low and `imem_addr` is 0. A `start` pulse loads `entry_pc` into the program counter, empties the stack, clears `stack_fault` and raises `busy`.
- R2: While busy, the opcode is word bits 31:26. Any opcode other than NOP (0x21), END (0x22), CALL (0x24), IFU (0x27) and IFC (0x28) is issued: `issue_valid` is high for one cycle, and `issue_word` holds the word in the cycle after it was fetched. Issues come out in program order. A NOP advances the program counter and issues nothing.
- R3: END drops `busy` and pulses `done` for one cycle. No further word is issued until the next `start`.
- R4: IFC evaluates the flags `cmp_flags[1]` (x) and `cmp_flags[0]` (y) against reference bits 25 (x) and 24 (y), using the mode in bits 23:22. Mode 0 is true if either flag equals its reference, mode 1 if both do, mode 2 if x does, and mode 3 if y does.
- R5: IFU is true when the bit of `bool_uni` selected by word bits 25:22 is 1.
- R6: For IF and CALL, the target is bits 21:10 and the count is bits 7:0. When a conditional is true, the instructions from the one after it up to target-1 run, and execution then continues at target+count.
- R7: When a conditional is false, execution continues at the target, so the count-long else-region runs, followed by what comes after it.
- R8: A count of 0 means there is no else-region. A true conditional continues through the target, and a false one skips straight to it.
- R9: CALL runs the region from target to target+count-1 and then resumes at the instruction after the CALL. Calls nest in last-in first-out order up to the stack depth (4 by default).
- R10: A push onto a full stack is dropped, and `stack_fault` goes high and stays high until the next `start`.
- R11: A conditional whose target is not above its own address pulses `target_err` for one cycle. It is treated as not taken and falls through to the next address, with no push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a program at `entry_pc` |
| entry_pc | input | 12 | Program entry address |
| imem_addr | output | 12 | Instruction fetch address (the program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| cmp_flags | input | 2 | Compare flags, bit 1 = x, bit 0 = y |
| bool_uni | input | 16 | Boolean uniform word |
| busy | output | 1 | A program is running |
| issue_valid | output | 1 | Non-flow instruction issued this cycle |
| issue_word | output | 32 | The issued instruction word |
| done | output | 1 | One-cycle pulse after END |
| target_err | output | 1 | One-cycle pulse for a conditional with a backward target |
| stack_fault | output | 1 | Sticky: a push was made to a full stack |

## Verification
The checker watches, on every cycle, the relations among the control outputs. Nothing is issued while idle or together with `done` or `target_err`. `done` always leaves the unit idle. The fault flag is sticky between starts, and the stack never holds more entries than its depth. Whether the right instructions are issued, and in the right order, can only be shown by the bench's programs. These cover each compare mode with taken and not-taken flag patterns, a uniform bit set and clear, empty else-regions, calls nested to the full depth and one level beyond it, and a backward conditional target.

// File: rtl/flowseq_pkg.sv
package flowseq_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned ADDR_W = 12;
   localparam int unsigned CNT_W  = 8;

   localparam logic [5:0] OPC_NOP  = 6'h21;
   localparam logic [5:0] OPC_END  = 6'h22;
   localparam logic [5:0] OPC_CALL = 6'h24;
   localparam logic [5:0] OPC_IFU  = 6'h27;
   localparam logic [5:0] OPC_IFC  = 6'h28;

   typedef enum logic [1:0] {
      CM_EITHER = 2'd0,
      CM_BOTH   = 2'd1,
      CM_XONLY  = 2'd2,
      CM_YONLY  = 2'd3
   } cmode_e;

   typedef struct packed {
      logic [ADDR_W-1:0] resume_pc;
      logic [ADDR_W-1:0] end_pc;
   } frame_t;

endpackage

// File: rtl/flowseq_cond.sv
module flowseq_cond
   import flowseq_pkg::*;
#(
   parameter int unsigned UNI_W = 16
) (
   input  logic             use_uni,
   input  logic [3:0]       sel_field,
   input  logic [1:0]       flags,
   input  logic [UNI_W-1:0] uni,
   output logic             cond
);
   localparam int unsigned SEL_W = $clog2(UNI_W);

   if (UNI_W < 2 || UNI_W > 16) begin : g_bad_uni
      $error("flowseq_cond: UNI_W must be 2..16");
   end

   logic   ref_x, ref_y, hit_x, hit_y, cmp_res;
   cmode_e mode;

   assign ref_x = sel_field[3];
   assign ref_y = sel_field[2];
   assign mode  = cmode_e'(sel_field[1:0]);
   assign hit_x = (flags[1] == ref_x);
   assign hit_y = (flags[0] == ref_y);

   always_comb begin
      unique case (mode)
         CM_EITHER: cmp_res = hit_x | hit_y;
         CM_BOTH:   cmp_res = hit_x & hit_y;
         CM_XONLY:  cmp_res = hit_x;
         default:   cmp_res = hit_y;
      endcase
   end

   logic uni_res;
   if (SEL_W == 4) begin : g_full_sel
      assign uni_res = uni[sel_field];
   end else begin : g_part_sel
      logic [3-SEL_W:0] hi_bits;
      assign hi_bits = sel_field[3:SEL_W];
      assign uni_res = (hi_bits == '0) ? uni[sel_field[SEL_W-1:0]] : 1'b0;
   end

   assign cond = use_uni ? uni_res : cmp_res;

endmodule

// File: rtl/flowseq_stack.sv
module flowseq_stack
   import flowseq_pkg::*;
#(
   parameter int unsigned DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clear,
   input  logic                       push,
   input  logic                       pop,
   input  frame_t                     push_frame,
   output frame_t                     top_frame,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH+1)-1:0] level
);
   localparam int unsigned LVL_W = $clog2(DEPTH+1);

   if (DEPTH < 1 || DEPTH > 64) begin : g_bad_depth
      $error("flowseq_stack: DEPTH must be 1..64");
   end

   logic [LVL_W-1:0] lvl_q;
   frame_t           slot_q [DEPTH];

   assign empty = (lvl_q == '0);
   assign full  = (lvl_q == LVL_W'(DEPTH));
   assign level = lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
      end else if (clear) begin
         lvl_q <= '0;
      end else if (push && !full) begin
         lvl_q <= lvl_q + 1'b1;
      end else if (pop && !empty) begin
         lvl_q <= lvl_q - 1'b1;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[i] <= '0;
         end else if (!clear && push && !full && lvl_q == LVL_W'(i)) begin
            slot_q[i] <= push_frame;
         end
      end
   end

   always_comb begin
      top_frame = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (lvl_q == LVL_W'(i + 1)) top_frame = slot_q[i];
      end
   end

endmodule

// File: rtl/flowseq_top.sv
module flowseq_top
   import flowseq_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned UNI_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [ADDR_W-1:0]   entry_pc,
   output logic [ADDR_W-1:0]   imem_addr,
   input  logic [WORD_W-1:0]   imem_data,
   input  logic [1:0]          cmp_flags,
   input  logic [UNI_W-1:0]    bool_uni,
   output logic                busy,
   output logic                issue_valid,
   output logic [WORD_W-1:0]   issue_word,
   output logic                done,
   output logic                target_err,
   output logic                stack_fault
);
   localparam int unsigned LVL_W = $clog2(DEPTH+1);

   logic [ADDR_W-1:0] pc_q;
   logic              busy_q, iv_q, done_q, terr_q, fault_q;
   logic [WORD_W-1:0] iw_q;

   logic [5:0]        opc;
   logic [ADDR_W-1:0] tgt, tgt_plus, pc_inc;
   logic [CNT_W-1:0]  cnt;
   logic              is_if, cond, back_tgt, at_end, exec;
   logic              st_push, st_pop, st_empty, st_full;
   frame_t            st_top, st_new;
   logic [LVL_W-1:0]  stk_level;

   assign opc      = imem_data[31:26];
   assign tgt      = imem_data[21:10];
   assign cnt      = imem_data[7:0];
   assign tgt_plus = tgt + ADDR_W'(cnt);
   assign pc_inc   = pc_q + 1'b1;
   assign is_if    = (opc == OPC_IFC) || (opc == OPC_IFU);
   assign back_tgt = (tgt <= pc_q);

   assign at_end = busy_q && !st_empty && (pc_q == st_top.end_pc);
   assign exec   = busy_q && !at_end && !start;

   flowseq_cond #(.UNI_W(UNI_W)) u_cond (
      .use_uni   (opc == OPC_IFU),
      .sel_field (imem_data[25:22]),
      .flags     (cmp_flags),
      .uni       (bool_uni),
      .cond      (cond)
   );

   always_comb begin
      st_push = 1'b0;
      st_new  = '0;
      if (exec && opc == OPC_CALL) begin
         st_push          = 1'b1;
         st_new.end_pc    = tgt_plus;
         st_new.resume_pc = pc_inc;
      end else if (exec && is_if && !back_tgt && cond && cnt != '0) begin
         st_push          = 1'b1;
         st_new.end_pc    = tgt;
         st_new.resume_pc = tgt_plus;
      end
   end

   assign st_pop = at_end && !start;

   flowseq_stack #(.DEPTH(DEPTH)) u_stack (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (start),
      .push       (st_push),
      .pop        (st_pop),
      .push_frame (st_new),
      .top_frame  (st_top),
      .empty      (st_empty),
      .full       (st_full),
      .level      (stk_level)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q    <= '0;
         busy_q  <= 1'b0;
         iv_q    <= 1'b0;
         iw_q    <= '0;
         done_q  <= 1'b0;
         terr_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         iv_q   <= 1'b0;
         done_q <= 1'b0;
         terr_q <= 1'b0;
         if (start) begin
            pc_q    <= entry_pc;
            busy_q  <= 1'b1;
            fault_q <= 1'b0;
         end else begin
            if (st_push && st_full) fault_q <= 1'b1;
            if (at_end) begin
               pc_q <= st_top.resume_pc;
            end else if (exec) begin
               unique case (opc)
                  OPC_END: begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                  end
                  OPC_CALL: pc_q <= tgt;
                  OPC_IFC, OPC_IFU: begin
                     if (back_tgt) begin
                        terr_q <= 1'b1;
                        pc_q   <= pc_inc;
                     end else if (cond) begin
                        pc_q <= pc_inc;
                     end else begin
                        pc_q <= tgt;
                     end
                  end
                  OPC_NOP: pc_q <= pc_inc;
                  default: begin
                     pc_q <= pc_inc;
                     iv_q <= 1'b1;
                     iw_q <= imem_data;
                  end
               endcase
            end
         end
      end
   end

   assign imem_addr   = pc_q;
   assign busy        = busy_q;
   assign issue_valid = iv_q;
   assign issue_word  = iw_q;
   assign done        = done_q;
   assign target_err  = terr_q;
   assign stack_fault = fault_q;

endmodule

// File: rtl/flowseq_chk.sv
module flowseq_chk #(
   parameter int unsigned DEPTH = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       start,
   input logic                       busy,
   input logic                       issue_valid,
   input logic                       done,
   input logic                       target_err,
   input logic                       stack_fault,
   input logic [$clog2(DEPTH+1)-1:0] level
);
   // R2
   idle_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !issue_valid);

   // R3
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !issue_valid);

   // R3
   stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !start |=> !busy && !done);

   // R10
   sticky_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stack_fault && !start |=> stack_fault);

   // R9
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= ($clog2(DEPTH+1))'(DEPTH));

   // R11
   err_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      target_err |-> !issue_valid && !done);
endmodule

bind flowseq_top flowseq_chk #(.DEPTH(DEPTH)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .issue_valid (issue_valid),
   .done        (done),
   .target_err  (target_err),
   .stack_fault (stack_fault),
   .level       (stk_level)
);

// File: tb/flowseq_top_tb.sv
module flowseq_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [11:0] entry_pc = '0;
   logic [11:0] imem_addr;
   logic [31:0] imem_data;
   logic [1:0]  cmp_flags = '0;
   logic [15:0] bool_uni = '0;
   logic        busy, issue_valid, done, target_err, stack_fault;
   logic [31:0] issue_word;

   always #5 clk = ~clk;

   logic [31:0] mem [64];
   assign imem_data = mem[imem_addr[5:0]];

   flowseq_top dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .entry_pc(entry_pc),
      .imem_addr(imem_addr), .imem_data(imem_data), .cmp_flags(cmp_flags),
      .bool_uni(bool_uni), .busy(busy), .issue_valid(issue_valid),
      .issue_word(issue_word), .done(done), .target_err(target_err),
      .stack_fault(stack_fault));

   int          n_chk = 0, n_bad = 0, err_seen = 0;
   logic [31:0] expq [$];
   string       cur_req = "";

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] w_alu(input int id);
      return {6'h01, 26'(id)};
   endfunction
   function automatic logic [31:0] w_ifc(input int mode, input bit rx, input bit ry, input int t, input int c);
      return {6'h28, rx, ry, 2'(mode), 12'(t), 2'b00, 8'(c)};
   endfunction
   function automatic logic [31:0] w_ifu(input int b, input int t, input int c);
      return {6'h27, 4'(b), 12'(t), 2'b00, 8'(c)};
   endfunction
   function automatic logic [31:0] w_call(input int t, input int c);
      return {6'h24, 4'b0, 12'(t), 2'b00, 8'(c)};
   endfunction
   localparam logic [31:0] W_END = {6'h22, 26'd0};
   localparam logic [31:0] W_NOP = {6'h21, 26'd0};

   // monitor: pop expected issues as the design produces them
   always @(negedge clk) begin
      if (rst_n && issue_valid) begin
         if (expq.size() == 0) check({cur_req, " unexpected issue"}, issue_word, 32'hxxxxxxxx);
         else check(cur_req, issue_word, expq.pop_front());
      end
      if (rst_n && target_err) err_seen++;
   end

   task automatic clear_mem();
      for (int i = 0; i < 64; i++) mem[i] = W_END;
   endtask

   task automatic run(input string req, input int entry, input bit exp_fault, input int exp_err);
      int cyc;
      cur_req = req;
      err_seen = 0;
      @(negedge clk);
      entry_pc = 12'(entry);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({req, " busy after start"}, 32'(busy), 32'd1);
      cyc = 0;
      while (!done && cyc < 400) begin
         @(negedge clk);
         cyc++;
      end
      check({req, " done pulse"}, 32'(done), 32'd1);
      check({req, " busy after done"}, 32'(busy), 32'd0);
      check({req, " queue drained"}, 32'(expq.size()), 32'd0);
      check({req, " stack_fault"}, 32'(stack_fault), 32'(exp_fault));
      check({req, " target_err count"}, 32'(err_seen), 32'(exp_err));
      expq.delete();
      @(negedge clk);
      check({req, " done one cycle"}, 32'(done), 32'd0);
   endtask

   task automatic load_if(input logic [31:0] w);
      clear_mem();
      mem[0] = w; mem[1] = w_alu(11); mem[2] = w_alu(12);
      mem[3] = w_alu(13); mem[4] = w_alu(14); mem[5] = w_alu(15); mem[6] = W_END;
   endtask

   task automatic exp_if(input bit taken);
      if (taken) begin expq.push_back(w_alu(11)); expq.push_back(w_alu(12)); end
      else begin expq.push_back(w_alu(13)); expq.push_back(w_alu(14)); end
      expq.push_back(w_alu(15));
   endtask

   task automatic do_ifc(input string req, input int mode, input bit rx, input bit ry,
                         input logic [1:0] fl, input bit taken);
      load_if(w_ifc(mode, rx, ry, 3, 2));
      cmp_flags = fl;
      exp_if(taken);
      run(req, 0, 1'b0, 0);
   endtask

   task automatic load_calls();
      clear_mem();
      for (int k = 0; k < 5; k++) begin
         mem[10*k]   = w_call(10*(k+1), 2);
         mem[10*k+1] = w_alu(100 + k);
         mem[10*k+2] = W_END;
      end
      mem[50] = w_alu(200); mem[51] = w_alu(201); mem[52] = W_END;
   endtask

   task automatic exp_deep4();
      expq.push_back(w_alu(200)); expq.push_back(w_alu(201));
      for (int k = 4; k >= 1; k--) expq.push_back(w_alu(100 + k));
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected < 150000 cycles", wd);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 busy idle", 32'(busy), 32'd0);
      check("R1 issue idle", 32'(issue_valid), 32'd0);
      check("R1 done idle", 32'(done), 32'd0);
      check("R1 fault idle", 32'(stack_fault), 32'd0);
      check("R1 addr zero", 32'(imem_addr), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 stays idle", 32'(busy), 32'd0);

      // R2 R3 straight line with NOP
      clear_mem();
      mem[0] = w_alu(1); mem[1] = W_NOP; mem[2] = w_alu(2); mem[3] = W_END;
      expq.push_back(w_alu(1)); expq.push_back(w_alu(2));
      run("R2 R3 straight", 0, 1'b0, 0);
      repeat (3) @(negedge clk);
      check("R3 no issue after end", 32'(issue_valid), 32'd0);

      // R4 R6 R7 compare modes (flags: bit1 x, bit0 y)
      do_ifc("R4 R6 mode0 true", 0, 1, 1, 2'b01, 1'b1);
      do_ifc("R4 R7 mode0 false", 0, 1, 1, 2'b00, 1'b0);
      do_ifc("R4 R6 mode1 true", 1, 1, 0, 2'b10, 1'b1);
      do_ifc("R4 R7 mode1 false", 1, 1, 0, 2'b11, 1'b0);
      do_ifc("R4 R6 mode2 true", 2, 0, 1, 2'b01, 1'b1);
      do_ifc("R4 R7 mode2 false", 2, 0, 0, 2'b10, 1'b0);
      do_ifc("R4 R7 mode3 false", 3, 0, 1, 2'b10, 1'b0);
      do_ifc("R4 R6 mode3 true", 3, 1, 1, 2'b01, 1'b1);

      // R5 uniform bit select
      load_if(w_ifu(5, 3, 2));
      bool_uni = 16'h0020; exp_if(1'b1);
      run("R5 R6 uniform set", 0, 1'b0, 0);
      bool_uni = 16'hFFDF; exp_if(1'b0);
      run("R5 R7 uniform clear", 0, 1'b0, 0);

      // R8 count zero
      clear_mem();
      mem[0] = w_ifc(2, 1, 0, 2, 0); mem[1] = w_alu(21); mem[2] = w_alu(22); mem[3] = W_END;
      cmp_flags = 2'b10;
      expq.push_back(w_alu(21)); expq.push_back(w_alu(22));
      run("R8 empty else taken", 0, 1'b0, 0);
      cmp_flags = 2'b00;
      expq.push_back(w_alu(22));
      run("R8 empty else skipped", 0, 1'b0, 0);

      // R9 nested calls to full depth
      load_calls();
      exp_deep4();
      run("R9 nested calls", 10, 1'b0, 0);

      // R10 one level too deep
      expq.push_back(w_alu(200)); expq.push_back(w_alu(201));
      run("R10 overflow", 0, 1'b1, 0);
      check("R10 fault held", 32'(stack_fault), 32'd1);
      exp_deep4();
      run("R10 R1 fault cleared by start", 10, 1'b0, 0);

      // R11 backward target
      clear_mem();
      mem[2] = w_ifc(0, 1, 1, 1, 1); mem[3] = w_alu(31); mem[4] = W_END;
      cmp_flags = 2'b11;
      expq.push_back(w_alu(31));
      run("R11 backward target", 2, 1'b0, 1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule